// File: doc/BRIEF.md
# Floating-Point Result Hazard Interlock

This block is an in-order pipeline slice that tracks the register writes of two-cycle floating-point operations (multiply, add, subtract, multiply-accumulate) until they are written back. It checks every register move against those pending writes. A two-cycle result reaches a CPU-side reader only through a forwarding path in its third execute stage. If a stall hits that stage, the forwarded value is lost, and a move that reads the register too early sees the old contents. Moves whose destination is another FPU register always get full forwarding, so they are never at risk.

When a move to the CPU side reads a register that still has a write pending, the block raises a hazard flag. With the interlock enabled, it also holds issue until the producer has written back. This gives the three-slot spacing that makes the read safe. Each cycle spent holding without a stall counts as one slot, and that slot is filled with a bubble. With the interlock disabled, the stale read can happen, so the failure can be reproduced and compared against the protected case.

The arithmetic is a stand-in with simple integer functions, because the hazard timing is the subject of the block. Stall freezes the whole slice, including the pending-write tracker.

Top module: `fmg_interlock`

## Requirements
- R1: Reset is synchronous and active high. It clears all pending entries, sets every FPU register to zero and drives rd_valid low. With nothing pending, hazard and issue_hold are low.
- R2: An instruction is accepted on a cycle with in_valid=1, stall=0 and issue_hold=0. The in_op codes are: 0 no-op, 1 load immediate, 2 multiply, 3 add, 4 subtract, 5 multiply-accumulate, 6 untracked FPU operation, 7 move. An accepted move raises rd_valid for one cycle after the next clock edge and presents rd_data, rd_dst and rd_to_cpu with it.
- R3: Results keep the low 32 bits. Multiply gives a*b, add gives a+b, subtract gives a-b and multiply-accumulate gives a*b plus the prior value of the destination register. The untracked operation writes ~a, and load immediate writes in_imm; both write at the accepting edge. A two-cycle result enters a pending slot and is written back on the third non-stalled edge after it is accepted. If a single-cycle write to the same register lands on that same edge, the single-cycle write wins.
- R4: Operands of arithmetic operations, of the untracked operation and of moves into the FPU side take the youngest pending result for that register. If no result is pending, they take the register file value.
- R5: A move into the CPU side (in_to_cpu=1) reads the youngest pending result for its source register. If that entry is marked lost, it reads the register file value instead.
- R6: A pending result is marked lost when a stall cycle occurs while it sits in the oldest slot, which is the forwarding stage.
- R7: hazard is 1 exactly when in_valid=1, in_op is a move, in_to_cpu=1 and in_src_a matches the destination of any pending result. A move into the FPU side is never flagged.
- R8: issue_hold equals hazard AND lock_en. A held move stays held for at most DEPTH non-stalled cycles. Every non-stalled held cycle advances the pending slots by one bubble.
- R9: During a stall no instruction is accepted and the pending slots do not advance. rd_valid is 0 after that edge.
- R10: With lock_en=0, issue_hold stays 0. A conflicting move into the CPU side issues at once and returns the old register value if its producer's result was lost.
- R11: Load immediate and the untracked operation never create pending entries, so a later move never flags a hazard because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_en | input | 1 | 1 enables the interlock hold |
| stall | input | 1 | Freezes the slice for this cycle |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 3 | Operation class code |
| in_dst | input | 3 | Destination register index |
| in_src_a | input | 3 | First source register index (move source) |
| in_src_b | input | 3 | Second source register index |
| in_to_cpu | input | 1 | Move destination is on the CPU side |
| in_imm | input | 32 | Immediate for load |
| issue_hold | output | 1 | Instruction held this cycle |
| hazard | output | 1 | Conflicting CPU-side move seen |
| rd_valid | output | 1 | A move was accepted on the previous edge |
| rd_to_cpu | output | 1 | Domain of that move's destination |
| rd_dst | output | 3 | That move's destination index |
| rd_data | output | 32 | Value that move actually read |

## Verification
The properties assume that lock_en, stall and in_valid carry known values from the first clock after reset. They also assume that in_to_cpu is meaningful only when in_op is a move. The stimulus drives every input from the bench on the falling edge, so these hold by construction. When a move is held, the bench either presents it again or replaces it, as a real issue stage would. Because no pending entry can be added while a hold is active, the counted bound on hold length holds for every stimulus the bench produces.

// File: rtl/fmg_pkg.sv
package fmg_pkg;

    localparam int DW   = 32;
    localparam int NREG = 8;
    localparam int RW   = $clog2(NREG);

    typedef logic [DW-1:0] word_t;
    typedef logic [RW-1:0] ridx_t;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_LDI = 3'd1,
        OP_MPY = 3'd2,
        OP_ADD = 3'd3,
        OP_SUB = 3'd4,
        OP_MAC = 3'd5,
        OP_CVT = 3'd6,
        OP_MOV = 3'd7
    } op_e;

    // One in-flight two-cycle result
    typedef struct packed {
        logic  vld;
        logic  lost;
        ridx_t dst;
        word_t data;
    } pend_t;

    function automatic logic is_two_cycle(op_e op);
        return (op == OP_MPY) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_MAC);
    endfunction

    function automatic logic is_single_write(op_e op);
        return (op == OP_LDI) || (op == OP_CVT);
    endfunction

    // Stand-in arithmetic: deterministic integer functions
    function automatic word_t arith(op_e op, word_t a, word_t b, word_t d);
        word_t r;
        case (op)
            OP_MPY:  r = a * b;
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_MAC:  r = (a * b) + d;
            OP_CVT:  r = ~a;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fmg_regfile.sv
module fmg_regfile
    import fmg_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmt_we,
    input  ridx_t             cmt_idx,
    input  word_t             cmt_data,
    input  logic              iss_we,
    input  ridx_t             iss_idx,
    input  word_t             iss_data,
    input  ridx_t [NRD-1:0]   rd_idx,
    output word_t [NRD-1:0]   rd_val
);

    word_t mem [NREG];

    // Issue-time write is placed last so it overrides a same-edge commit
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            if (cmt_we) mem[cmt_idx] <= cmt_data;
            if (iss_we) mem[iss_idx] <= iss_data;
        end
    end

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            assign rd_val[p] = mem[rd_idx[p]];
        end
    endgenerate

endmodule

// File: rtl/fmg_tracker.sv
module fmg_tracker
    import fmg_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               push,
    input  ridx_t              push_dst,
    input  word_t              push_data,
    output pend_t [DEPTH-1:0]  slots,
    output logic               cmt_we,
    output ridx_t              cmt_idx,
    output word_t              cmt_data
);

    localparam int LAST = DEPTH - 1;

    pend_t [DEPTH-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (!stall) begin
            slot_q[0] <= push ? '{vld: 1'b1, lost: 1'b0, dst: push_dst, data: push_data}
                              : '0;
            for (int k = 1; k < DEPTH; k++) slot_q[k] <= slot_q[k-1];
        end else if (slot_q[LAST].vld) begin
            // stall while in the forwarding stage: forward is lost
            slot_q[LAST].lost <= 1'b1;
        end
    end

    assign slots    = slot_q;
    assign cmt_we   = !stall && slot_q[LAST].vld;
    assign cmt_idx  = slot_q[LAST].dst;
    assign cmt_data = slot_q[LAST].data;

endmodule

// File: rtl/fmg_fwd.sv
module fmg_fwd
    import fmg_pkg::*;
#(
    parameter int DEPTH      = 3,
    parameter bit LOST_AWARE = 1'b0
) (
    input  pend_t [DEPTH-1:0] slots,
    input  ridx_t             idx,
    input  word_t             rf_val,
    output word_t             val
);

    logic [DEPTH-1:0] match;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_m
            assign match[k] = slots[k].vld && (slots[k].dst == idx);
        end
    endgenerate

    // Oldest first, so the youngest match is applied last
    always_comb begin
        val = rf_val;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (match[k]) val = (LOST_AWARE && slots[k].lost) ? rf_val : slots[k].data;
        end
    end

endmodule

// File: rtl/fmg_hazard.sv
module fmg_hazard
    import fmg_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  pend_t [DEPTH-1:0] slots,
    input  logic              in_valid,
    input  op_e               op,
    input  logic              to_cpu,
    input  ridx_t             src,
    input  logic              lock_en,
    output logic              hazard,
    output logic              hold
);

    logic [DEPTH-1:0] conflict;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_c
            assign conflict[k] = slots[k].vld && (slots[k].dst == src);
        end
    endgenerate

    assign hazard = in_valid && (op == OP_MOV) && to_cpu && (|conflict);
    assign hold   = hazard && lock_en;

endmodule

// File: rtl/fmg_interlock.sv
module fmg_interlock
    import fmg_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lock_en,
    input  logic        stall,
    input  logic        in_valid,
    input  logic [2:0]  in_op,
    input  logic [2:0]  in_dst,
    input  logic [2:0]  in_src_a,
    input  logic [2:0]  in_src_b,
    input  logic        in_to_cpu,
    input  logic [31:0] in_imm,
    output logic        issue_hold,
    output logic        hazard,
    output logic        rd_valid,
    output logic        rd_to_cpu,
    output logic [2:0]  rd_dst,
    output logic [31:0] rd_data
);

    localparam int NRD = 3;

    op_e               op;
    logic              issue;
    pend_t [DEPTH-1:0] slots;
    logic              cmt_we;
    ridx_t             cmt_idx;
    word_t             cmt_data;
    ridx_t [NRD-1:0]   rf_idx;
    word_t [NRD-1:0]   rf_val;
    word_t             va, vb, vd, vcpu, result;

    assign op    = op_e'(in_op);
    assign issue = in_valid && !stall && !issue_hold;

    assign rf_idx[0] = in_src_a;
    assign rf_idx[1] = in_src_b;
    assign rf_idx[2] = in_dst;

    fmg_regfile #(.NRD(NRD)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .cmt_we   (cmt_we),
        .cmt_idx  (cmt_idx),
        .cmt_data (cmt_data),
        .iss_we   (issue && is_single_write(op)),
        .iss_idx  (in_dst),
        .iss_data ((op == OP_LDI) ? in_imm : result),
        .rd_idx   (rf_idx),
        .rd_val   (rf_val)
    );

    fmg_tracker #(.DEPTH(DEPTH)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .push      (issue && is_two_cycle(op)),
        .push_dst  (in_dst),
        .push_data (result),
        .slots     (slots),
        .cmt_we    (cmt_we),
        .cmt_idx   (cmt_idx),
        .cmt_data  (cmt_data)
    );

    fmg_fwd #(.DEPTH(DEPTH), .LOST_AWARE(1'b0)) u_fwd_a (
        .slots(slots), .idx(in_src_a), .rf_val(rf_val[0]), .val(va));
    fmg_fwd #(.DEPTH(DEPTH), .LOST_AWARE(1'b0)) u_fwd_b (
        .slots(slots), .idx(in_src_b), .rf_val(rf_val[1]), .val(vb));
    fmg_fwd #(.DEPTH(DEPTH), .LOST_AWARE(1'b0)) u_fwd_d (
        .slots(slots), .idx(in_dst),   .rf_val(rf_val[2]), .val(vd));
    fmg_fwd #(.DEPTH(DEPTH), .LOST_AWARE(1'b1)) u_fwd_cpu (
        .slots(slots), .idx(in_src_a), .rf_val(rf_val[0]), .val(vcpu));

    assign result = arith(op, va, vb, vd);

    fmg_hazard #(.DEPTH(DEPTH)) u_haz (
        .slots    (slots),
        .in_valid (in_valid),
        .op       (op),
        .to_cpu   (in_to_cpu),
        .src      (in_src_a),
        .lock_en  (lock_en),
        .hazard   (hazard),
        .hold     (issue_hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_to_cpu <= 1'b0;
            rd_dst    <= '0;
            rd_data   <= '0;
        end else begin
            rd_valid <= issue && (op == OP_MOV);
            if (issue && (op == OP_MOV)) begin
                rd_to_cpu <= in_to_cpu;
                rd_dst    <= in_dst;
                rd_data   <= in_to_cpu ? vcpu : va;
            end
        end
    end

endmodule

// File: rtl/fmg_checker.sv
module fmg_checker
    import fmg_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              lock_en,
    input logic              stall,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic              in_to_cpu,
    input logic              issue_hold,
    input logic              hazard,
    input logic              rd_valid,
    input pend_t [DEPTH-1:0] slots
);

    logic [DEPTH-1:0] vld_vec;
    int unsigned      hold_run;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_v
            assign vld_vec[k] = slots[k].vld;
        end
    endgenerate

    // counts non-stalled cycles of one uninterrupted hold
    always_ff @(posedge clk) begin
        if (rst)                        hold_run <= 0;
        else if (!issue_hold)           hold_run <= 0;
        else if (!stall)                hold_run <= hold_run + 1;
    end

    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (vld_vec == '0 && !rd_valid));

    p_fpu_move_unflagged_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e'(in_op) == OP_MOV && !in_to_cpu) |-> !hazard);

    p_idle_no_hazard_r7: assert property (@(posedge clk) disable iff (rst)
        (vld_vec == '0) |-> !hazard);

    p_hold_cpu_move_r8: assert property (@(posedge clk) disable iff (rst)
        issue_hold |-> (hazard && in_valid && op_e'(in_op) == OP_MOV && in_to_cpu));

    p_hold_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        (hold_run >= DEPTH) |-> !issue_hold);

    p_stall_freezes_r9: assert property (@(posedge clk) disable iff (rst)
        stall |=> (vld_vec == $past(vld_vec) && !rd_valid));

    p_off_no_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !lock_en |-> !issue_hold);

endmodule

bind fmg_interlock fmg_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lock_en    (lock_en),
    .stall      (stall),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_to_cpu  (in_to_cpu),
    .issue_hold (issue_hold),
    .hazard     (hazard),
    .rd_valid   (rd_valid),
    .slots      (slots)
);

// File: tb/fmg_interlock_test.sv
module fmg_interlock_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock_en = 1'b0, stall = 1'b0, in_valid = 1'b0, in_to_cpu = 1'b0;
    logic [2:0]  in_op = '0, in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [31:0] in_imm = '0;
    logic        issue_hold, hazard, rd_valid, rd_to_cpu;
    logic [2:0]  rd_dst;
    logic [31:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmg_interlock #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .lock_en(lock_en), .stall(stall), .in_valid(in_valid),
        .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_to_cpu(in_to_cpu), .in_imm(in_imm), .issue_hold(issue_hold), .hazard(hazard),
        .rd_valid(rd_valid), .rd_to_cpu(rd_to_cpu), .rd_dst(rd_dst), .rd_data(rd_data));

    int checks = 0;
    int fails  = 0;
    bit last_hold;

    // behavioural reference: list of pending writes, youngest at index 0
    typedef struct { int dst; logic [31:0] data; int age; bit lost; } ment_t;
    ment_t       q[$];
    logic [31:0] mrf [8];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int idx, input bit lost_aware);
        for (int i = 0; i < q.size(); i++)
            if (q[i].dst == idx) return (lost_aware && q[i].lost) ? mrf[idx] : q[i].data;
        return mrf[idx];
    endfunction

    function automatic bit m_pending(input int idx);
        for (int i = 0; i < q.size(); i++) if (q[i].dst == idx) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input bit v, input int op, input int dst, input int a, input int b,
                        input bit cpu, input logic [31:0] imm, input bit st);
        bit e_haz, e_hold, iss, e_rv;
        logic [31:0] va, vb, vd, res, e_data;
        in_valid = v; in_op = op[2:0]; in_dst = dst[2:0]; in_src_a = a[2:0];
        in_src_b = b[2:0]; in_to_cpu = cpu; in_imm = imm; stall = st;
        #1;
        e_haz  = v && op == 7 && cpu && m_pending(a);
        e_hold = e_haz && lock_en;
        check(hazard === e_haz,      "R7 hazard", {31'd0, hazard}, {31'd0, e_haz});
        check(issue_hold === e_hold, "R8 issue_hold", {31'd0, issue_hold}, {31'd0, e_hold});
        last_hold = e_hold;
        iss = v && !st && !e_hold;
        va = m_read(a, 0); vb = m_read(b, 0); vd = m_read(dst, 0);
        case (op)
            2: res = va * vb;
            3: res = va + vb;
            4: res = va - vb;
            5: res = (va * vb) + vd;
            6: res = ~va;
            default: res = '0;
        endcase
        e_rv   = iss && op == 7;
        e_data = cpu ? m_read(a, 1) : va;
        if (!st) begin
            for (int i = q.size() - 1; i >= 0; i--)
                if (q[i].age == DEPTH - 1) begin mrf[q[i].dst] = q[i].data; q.delete(i); end
            foreach (q[i]) q[i].age++;
            if (iss && op == 1) mrf[dst] = imm;
            if (iss && op == 6) mrf[dst] = res;
            if (iss && op >= 2 && op <= 5) q.push_front('{dst, res, 0, 1'b0});
        end else begin
            foreach (q[i]) if (q[i].age == DEPTH - 1) q[i].lost = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        check(rd_valid === e_rv, "R2 rd_valid", {31'd0, rd_valid}, {31'd0, e_rv});
        if (e_rv) begin
            check(rd_data === e_data, cpu ? "R5 rd_data" : "R4 rd_data", rd_data, e_data);
            check(rd_dst === dst[2:0], "R2 rd_dst", {29'd0, rd_dst}, dst);
            check(rd_to_cpu === cpu, "R2 rd_to_cpu", {31'd0, rd_to_cpu}, {31'd0, cpu});
        end
    endtask

    task automatic nop(input bit st);
        step(0, 0, 0, 0, 0, 0, 0, st);
    endtask

    // issue a move, re-presenting it while held; counts held non-stall cycles
    task automatic mov_wait(input int src, input bit cpu, input int stall_at, output int held);
        int tries = 0;
        held = 0;
        step(1, 7, 1, src, 0, cpu, 0, 0);
        while (last_hold) begin
            held++;
            tries++;
            if (tries == stall_at) begin
                step(1, 7, 1, src, 0, cpu, 0, 1);
                step(1, 7, 1, src, 0, cpu, 0, 1);
            end
            step(1, 7, 1, src, 0, cpu, 0, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int held;
        for (int i = 0; i < 8; i++) mrf[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state at the ports
        check(rd_valid === 1'b0,   "R1 rd_valid after reset", {31'd0, rd_valid}, 0);
        check(issue_hold === 1'b0, "R1 hold after reset", {31'd0, issue_hold}, 0);
        check(hazard === 1'b0,     "R1 hazard after reset", {31'd0, hazard}, 0);
        for (int r = 0; r < 8; r++) begin
            step(1, 7, 0, r, 0, 0, 0, 0);
            check(rd_data === 32'd0, "R1 register zero", rd_data, 0);
        end

        step(1, 1, 1, 0, 0, 0, 32'd5, 0);   // LDI r1 = 5
        step(1, 1, 2, 0, 0, 0, 32'd7, 0);   // LDI r2 = 7

        // R6 R10: stall in forwarding stage, interlock off -> stale read
        lock_en = 1'b0;
        step(1, 2, 3, 1, 2, 0, 0, 0);       // MPY r3 = 35
        nop(0); nop(0); nop(1);
        mov_wait(3, 1, 0, held);
        check(held == 0,          "R10 no hold when off", held, 0);
        check(rd_data === 32'd0,  "R6 stale value after lost forward", rd_data, 0);

        // R10: off, no stall, back-to-back -> forwarded correctly
        step(1, 3, 3, 1, 2, 0, 0, 0);       // ADD r3 = 12
        mov_wait(3, 1, 0, held);
        check(rd_data === 32'd12, "R5 forwarded read when off", rd_data, 12);
        nop(0); nop(0); nop(0);

        // R8: interlock on, same stalled sequence -> one hold, correct value
        lock_en = 1'b1;
        step(1, 3, 4, 1, 2, 0, 0, 0);       // ADD r4 = 12
        nop(0); nop(0); nop(1);
        mov_wait(4, 1, 0, held);
        check(held == 1,          "R8 one slot hold", held, 1);
        check(rd_data === 32'd12, "R8 correct after hold", rd_data, 12);

        // R8: immediate conflicting move -> DEPTH slots of hold
        step(1, 4, 5, 2, 1, 0, 0, 0);       // SUB r5 = 2
        mov_wait(5, 1, 0, held);
        check(held == DEPTH,      "R8 full hold", held, DEPTH);
        check(rd_data === 32'd2,  "R3 subtract result", rd_data, 2);

        // R9: stall inside a hold does not consume slots
        step(1, 2, 0, 2, 2, 0, 0, 0);       // MPY r0 = 49
        mov_wait(0, 1, 1, held);
        check(held == DEPTH,      "R9 stall adds no slot", held, DEPTH);
        check(rd_data === 32'd49, "R3 multiply result", rd_data, 49);

        // R4 R7: FPU-side move right after producer, never held
        step(1, 5, 6, 1, 2, 0, 0, 0);       // MAC r6 = 35 + 0
        mov_wait(6, 0, 0, held);
        check(held == 0,          "R7 fpu move not held", held, 0);
        check(rd_data === 32'd35, "R4 forwarded mac", rd_data, 35);
        nop(0); nop(0); nop(0);

        // R11: untracked op followed by CPU move
        step(1, 6, 7, 1, 0, 0, 0, 0);       // CVT r7 = ~5
        mov_wait(7, 1, 0, held);
        check(held == 0,                 "R11 no hold after untracked", held, 0);
        check(rd_data === 32'hFFFFFFFA, "R11 untracked result", rd_data, 32'hFFFFFFFA);

        // random streams, interlock on then off
        for (int pass = 0; pass < 2; pass++) begin
            lock_en = (pass == 0);
            for (int n = 0; n < 4000; n++) begin
                int op;
                op = $urandom_range(0, 9);
                if (op > 7) op = 7;
                step($urandom_range(0, 7) != 0, op, $urandom_range(0, 3), $urandom_range(0, 3),
                     $urandom_range(0, 3), $urandom_range(0, 1), $urandom, $urandom_range(0, 4) == 0);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule